// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block watches a running BCD calendar and raises an alarm interrupt when the calendar agrees with a programmed alarm time. It receives the current second, minute, hour, day of month, month and three-digit year, together with a one-cycle strobe that marks each one-second advance. Comparison takes place only on a strobe cycle.

The match is a logical OR over the individually enabled fields. Any single enabled field that equals its stored alarm value is enough to fire. A firing alarm sets a sticky pending flag, which also drives the level interrupt output. Software clears the flag by writing one to the status location.

The strobe acts as a valid marker with no ready. The matcher always accepts a calendar sample, so it never applies back-pressure, and a sample offered without the strobe is not consumed. The register port is a plain write-only strobe port.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_pending` and `alarm_irq` are 0, all field enables and the global enable are 0, and every stored alarm value is 0.
- R2: Register map on `wr_addr`:
  - 0 is control. Bit 0 enables the second compare, bit 1 the minute, bit 2 the hour, bit 3 the day, bit 4 the month and bit 5 the year. Bit 6 is the global alarm enable.
  - 1 to 6 hold the alarm values for second, minute, hour, day, month and year, in that order.
  - 7 is the status-clear location.
- R3: When `sec_tick` is high, the global enable is set, and an enabled field equals its alarm value, then `alarm_pending` and `alarm_irq` are 1 from the next clock edge.
- R4: Fields are ORed. One enabled field that matches fires the alarm even when every other enabled field mismatches.
- R5: A field whose enable bit is 0 never causes a fire, even when its value matches.
- R6: With the global enable bit 0, no match fires.
- R7: A matching calendar presented while `sec_tick` is low does not fire.
- R8: Stored alarm values are masked on write. Second and minute keep 7 bits, hour and day keep 6 bits, month keeps 5 bits and year keeps 12 bits.
- R9: The year compare covers all 12 bits: two BCD digits in bits [7:0] and the hundreds digit in bits [11:8]. A hundreds-digit mismatch prevents a fire.
- R10: Writing address 7 with bit 1 set clears `alarm_pending` and `alarm_irq` from the next edge. A write to address 7 with bit 1 clear has no effect.
- R11: If a fire and a clear write occur in the same cycle, the fire wins and the flag stays set.
- R12: The alarm fires again on every strobe on which the match condition holds, including one that comes after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe marking a calendar advance; valid for the calendar inputs |
| cal_sec | input | 7 | Current BCD second |
| cal_min | input | 7 | Current BCD minute |
| cal_hour | input | 6 | Current BCD hour |
| cal_day | input | 6 | Current BCD day of month |
| cal_mon | input | 5 | Current month in the comparator's encoding |
| cal_year | input | 12 | Current three-digit BCD year |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 12 | Register write data |
| alarm_pending | output | 1 | Sticky alarm status flag |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The assertions check the following on every cycle:
- the flag never rises without a strobe;
- it never rises while the global enable is off;
- a strobed match always sets it;
- it holds until a clear write;
- a clear write without a simultaneous fire drops it.

Only the directed scenarios can show the field-level behaviour:
- which address and bit reach which comparator;
- that write masking takes effect;
- that the year hundreds digit is compared;
- that disabled fields and the OR across fields behave as stated.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS   = 6;
  localparam int SEC_W        = 7;
  localparam int MIN_W        = 7;
  localparam int HOUR_W       = 6;
  localparam int DAY_W        = 6;
  localparam int MON_W        = 5;
  localparam int YEAR_W       = 12;
  localparam int FIELD_MAX_W  = YEAR_W;
  localparam int DATA_W       = FIELD_MAX_W;
  localparam int ADDR_W       = 3;
  localparam int CTRL_ADDR    = 0;
  localparam int STAT_ADDR    = 7;
  localparam int GLOBAL_BIT   = NUM_FIELDS;
  localparam int CTRL_W       = NUM_FIELDS + 1;
  localparam int STAT_ALM_BIT = 1;

  typedef logic [FIELD_MAX_W-1:0] field_t;

  function automatic int field_w(input int idx);
    case (idx)
      0:       return SEC_W;
      1:       return MIN_W;
      2:       return HOUR_W;
      3:       return DAY_W;
      4:       return MON_W;
      default: return YEAR_W;
    endcase
  endfunction

  function automatic field_t field_mask(input int idx);
    return field_t'((1 << field_w(idx)) - 1);
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [DATA_W-1:0]                      wr_data,
  output logic [NUM_FIELDS-1:0]                  field_en,
  output logic                                   glob_en,
  output logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] alarm_val
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                         ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))    ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign field_en = ctrl_q[NUM_FIELDS-1:0];
  assign glob_en  = ctrl_q[GLOBAL_BIT];

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam field_t MASK = field_mask(gi);
    always_ff @(posedge clk) begin
      if (!rst_n)
        alarm_val[gi] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(gi + 1))
        alarm_val[gi] <= wr_data[FIELD_MAX_W-1:0] & MASK;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] cal_val,
  input  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] alarm_val,
  input  logic [NUM_FIELDS-1:0]                  field_en,
  input  logic                                   glob_en,
  output logic                                   hit
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_eq
    assign eq[gi] = (cal_val[gi] == alarm_val[gi]);
  end

  assign hit = glob_en & (|(eq & field_en));
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [SEC_W-1:0]  cal_sec,
  input  logic [MIN_W-1:0]  cal_min,
  input  logic [HOUR_W-1:0] cal_hour,
  input  logic [DAY_W-1:0]  cal_day,
  input  logic [MON_W-1:0]  cal_mon,
  input  logic [YEAR_W-1:0] cal_year,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              alarm_pending,
  output logic              alarm_irq
);
  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] cal_vec;
  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] alarm_val;
  logic [NUM_FIELDS-1:0]                  field_en;
  logic                                   glob_en;
  logic                                   hit;
  logic                                   clr_wr;

  assign cal_vec[0] = FIELD_MAX_W'(cal_sec);
  assign cal_vec[1] = FIELD_MAX_W'(cal_min);
  assign cal_vec[2] = FIELD_MAX_W'(cal_hour);
  assign cal_vec[3] = FIELD_MAX_W'(cal_day);
  assign cal_vec[4] = FIELD_MAX_W'(cal_mon);
  assign cal_vec[5] = FIELD_MAX_W'(cal_year);

  rtc_alarm_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .field_en (field_en),
    .glob_en  (glob_en),
    .alarm_val(alarm_val)
  );

  rtc_alarm_cmp u_cmp (
    .cal_val  (cal_vec),
    .alarm_val(alarm_val),
    .field_en (field_en),
    .glob_en  (glob_en),
    .hit      (hit)
  );

  assign clr_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR)) && wr_data[STAT_ALM_BIT];

  rtc_alarm_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sec_tick & hit),
    .clr_i (clr_wr),
    .flag_o(alarm_pending)
  );

  assign alarm_irq = alarm_pending;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              hit,
  input logic              glob_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              alarm_pending
);
  logic clr_seen;
  assign clr_seen = wr_en && (wr_addr == ADDR_W'(STAT_ADDR)) && wr_data[STAT_ALM_BIT];

  AST_NO_FIRE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alarm_pending) |=> !alarm_pending); // R7
  AST_NO_FIRE_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !alarm_pending) |=> !alarm_pending); // R6
  AST_TICK_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> alarm_pending); // R3
  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_pending && !clr_seen) |=> alarm_pending); // R10
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_seen && !(sec_tick && hit)) |=> !alarm_pending); // R10
  AST_FIRE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_seen && sec_tick && hit) |=> alarm_pending); // R11
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_tick     (sec_tick),
  .hit          (hit),
  .glob_en      (glob_en),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .alarm_pending(alarm_pending)
);

// File: tb/rtc_alarm_match_tb_top.sv
module rtc_alarm_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [6:0]  cal_sec = '0;
  logic [6:0]  cal_min = '0;
  logic [5:0]  cal_hour = '0;
  logic [5:0]  cal_day = '0;
  logic [4:0]  cal_mon = '0;
  logic [11:0] cal_year = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        alarm_pending;
  logic        alarm_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_match dut_i (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic exp);
    check({req, " pending"}, alarm_pending, exp);
    check({req, " irq"}, alarm_irq, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cal(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] d, input logic [4:0] mo, input logic [11:0] y);
    cal_sec = s; cal_min = m; cal_hour = h; cal_day = d; cal_mon = mo; cal_year = y;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic clear_alarm();
    wr(3'd7, 12'h002);
  endtask

  task automatic t_reset();
    check_out("R1 reset", 1'b0);
    set_cal(0, 0, 0, 0, 0, 0);
    tick();
    check_out("R1 enables cleared after reset", 1'b0);
  endtask

  task automatic t_single();
    wr(3'd1, 12'h030);
    wr(3'd0, 12'h041);            // R2 sec enable + global
    set_cal(7'h29, 0, 0, 0, 0, 0);
    tick();
    check_out("R3 sec mismatch", 1'b0);
    set_cal(7'h30, 0, 0, 0, 0, 0);
    tick();
    check_out("R3 sec match fires", 1'b1);
    clear_alarm();
    check_out("R10 clear", 1'b0);
  endtask

  task automatic t_or();
    wr(3'd2, 12'h045); wr(3'd3, 12'h012); wr(3'd4, 12'h015); wr(3'd5, 12'h007);
    wr(3'd0, 12'h05E);            // R2 min,hour,day,month + global
    set_cal(0, 7'h11, 6'h01, 6'h02, 5'h07, 0);
    tick();
    check_out("R4 month alone matches", 1'b1);
    clear_alarm();
    set_cal(0, 7'h45, 6'h01, 6'h02, 5'h03, 0);
    tick();
    check_out("R4 minute alone matches", 1'b1);
    clear_alarm();
    set_cal(0, 7'h44, 6'h01, 6'h02, 5'h03, 0);
    tick();
    check_out("R4 nothing matches", 1'b0);
  endtask

  task automatic t_disabled();
    wr(3'd1, 12'h050);
    wr(3'd0, 12'h041);
    set_cal(7'h10, 7'h45, 6'h12, 6'h15, 5'h07, 0);
    tick();
    check_out("R5 disabled fields ignored", 1'b0);
  endtask

  task automatic t_global();
    wr(3'd0, 12'h03F);
    set_cal(7'h50, 7'h45, 6'h12, 6'h15, 5'h07, 0);
    tick();
    check_out("R6 global off", 1'b0);
  endtask

  task automatic t_nostrobe();
    wr(3'd0, 12'h041);
    set_cal(7'h50, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    check_out("R7 no strobe", 1'b0);
  endtask

  task automatic t_mask();
    wr(3'd1, 12'hFB5);            // R8 stored as 7'h35
    wr(3'd0, 12'h041);
    set_cal(7'h35, 0, 0, 0, 0, 0);
    tick();
    check_out("R8 second masked", 1'b1);
    clear_alarm();
    wr(3'd5, 12'hFE9);            // R8 month keeps 5 bits -> 5'h09
    wr(3'd0, 12'h050);
    set_cal(0, 0, 0, 0, 5'h09, 0);
    tick();
    check_out("R8 month masked", 1'b1);
    clear_alarm();
  endtask

  task automatic t_year();
    wr(3'd6, 12'h123);
    wr(3'd0, 12'h060);
    set_cal(0, 0, 0, 0, 0, 12'h023);
    tick();
    check_out("R9 hundreds differ", 1'b0);
    set_cal(0, 0, 0, 0, 0, 12'h123);
    tick();
    check_out("R9 full year match", 1'b1);
  endtask

  task automatic t_clear();
    wr(3'd7, 12'h001);
    check_out("R10 bit1 clear no effect", 1'b1);
    wr(3'd7, 12'h002);
    check_out("R10 bit1 clears", 1'b0);
  endtask

  task automatic t_setwins();
    @(negedge clk);
    sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd7; wr_data = 12'h002;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    check_out("R11 fire beats clear", 1'b1);
  endtask

  task automatic t_refire();
    clear_alarm();
    tick();
    check_out("R12 refire after clear", 1'b1);
    clear_alarm();
    tick();
    check_out("R12 refire again", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_or();
    t_disabled();
    t_global();
    t_nostrobe();
    t_mask();
    t_year();
    t_clear();
    wr(3'd6, 12'h123); wr(3'd0, 12'h060);
    set_cal(0, 0, 0, 0, 0, 12'h123);
    t_setwins();
    t_refire();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule